// File: doc/BRIEF.md
# External Interrupt Line Controller

The block takes 28 asynchronous interrupt pins. Each pin passes through a synchronizer. A trigger detector then watches it in one of five modes: active-low level, active-high level, falling edge, rising edge or either edge. Every detected event sets a sticky pending bit.

A mask register gates the pending bits before they reach four grouped interrupt outputs. The groups are unequal in size (4, 8, 8 and 8 lines) and feed a parent interrupt controller. The handler for a group reads the pending and mask registers to find which lines fired. It then clears the lines it has served by writing ones to the pending register.

Software reaches four 32-bit word registers over a plain single-cycle port: address, write enable, write data and combinational read data. The registers are:

| Address | Register |
|---|---|
| 0 | mask |
| 1 | pending |
| 2 | trigger configuration for lines 0–15 |
| 3 | trigger configuration for lines 16–27 |

Two neighbouring lines always share one trigger field.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Each pin passes through two synchronizer flops before detection. A qualifying pin change driven before clock edge n shows in the pending register right after edge n+2.
- R2: Mask register, address 0: bit i = 1 masks line i, bit i = 0 enables it. Bits 27:0 are writable. The register reads back what was written to those bits.
- R3: Pending register, address 1: writing 1 to bit i clears line i. Writing 0 leaves the bit unchanged. A write can never set a pending bit.
- R4: If a line detects an event in the same cycle as a clear write to that line, the event wins and the bit stays set. In a level mode, a pending bit is set again on every cycle the level is active.
- R5: Line j uses pair index k = j/2. Pairs 0–7 live in the register at address 2 and pairs 8–13 in the register at address 3. The 3-bit field for pair k sits at bits [(k mod 8)*4 +: 3] of its register.
- R6: Trigger codes: 000 = low level, 001 = high level, 010 and 011 = falling edge, 100 and 101 = rising edge, 110 and 111 = both edges.
- R7: An edge mode gives one event per qualifying transition of the synchronized pin. A steady pin and the opposite transition give none.
- R8: Output grp_irq[0] serves lines 0–3, grp_irq[1] lines 4–11, grp_irq[2] lines 12–19 and grp_irq[3] lines 20–27.
- R9: A group output is high exactly when some line in its range is both pending and unmasked. Masked lines still set their pending bits.
- R10: The following bits read as zero and ignore writes: bits 31:28 of mask and pending, bit 3 of every configuration nibble, and bits 31:24 of the register at address 3.
- R11: During and right after reset, all lines are masked, nothing is pending, every configuration field is 000 and all group outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pins | input | 28 | Asynchronous interrupt pins, line i on bit i |
| bus_we | input | 1 | Register write enable, taken at the clock edge |
| bus_addr | input | 2 | Word address: 0 mask, 1 pending, 2 config low, 3 config high |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| grp_irq | output | 4 | Grouped interrupt outputs to the parent controller |

## Verification
The bench builds the block with its default two-stage synchronizer and the full 28-line map. At that size it can sweep every line through all five trigger modes. Odd and even lines alternate between the two aliased codes of each edge mode, so every code value is used.

For each line/mode pair, the bench checks:
- the exact pending word,
- the latch while masked,
- the single group output that must rise,
- the clear-versus-event race in level modes,
- the silence after the opposite edge.

Configuration readback is compared per nibble against values the bench computes by shifting, which covers the paired field map and the bits that read as zero.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int NUM_LINES      = 28;
    localparam int NUM_PAIRS      = NUM_LINES / 2;
    localparam int NUM_GROUPS     = 4;
    localparam int REG_W          = 32;
    localparam int FIELD_W        = 3;
    localparam int NIBBLE_W       = 4;
    localparam int FIELDS_PER_REG = REG_W / NIBBLE_W;
    localparam int ADDR_W         = 2;

    typedef enum logic [2:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MASK = 2'd0,
        ADDR_PEND = 2'd1,
        ADDR_CFG0 = 2'd2,
        ADDR_CFG1 = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             we;
        reg_addr_e        addr;
        logic [REG_W-1:0] wdata;
    } bus_req_t;

    // Map a 3-bit trigger code to its detection mode.
    function automatic trig_e decode_trig(input logic [FIELD_W-1:0] code);
        trig_e m;
        case (code[2:1])
            2'b00:   m = code[0] ? TRIG_HIGH : TRIG_LOW;
            2'b01:   m = TRIG_FALL;
            2'b10:   m = TRIG_RISE;
            default: m = TRIG_BOTH;
        endcase
        return m;
    endfunction

    // First line of group g: 4, 8, 8, 8 sizes.
    function automatic int group_lo(input int g);
        return (g == 0) ? 0 : 4 + 8 * (g - 1);
    endfunction

    function automatic int group_hi(input int g);
        return (g == 0) ? 3 : group_lo(g) + 7;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LINES-1:0]         lvl,
    input  logic [LINES*FIELD_W-1:0] codes,
    output logic [LINES-1:0]         evt
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic  prev_q;
        logic  hit;
        trig_e mode;

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[i];
        end

        assign mode = decode_trig(codes[i*FIELD_W +: FIELD_W]);

        always_comb begin
            case (mode)
                TRIG_LOW:  hit = ~lvl[i];
                TRIG_HIGH: hit = lvl[i];
                TRIG_FALL: hit = prev_q & ~lvl[i];
                TRIG_RISE: hit = ~prev_q & lvl[i];
                TRIG_BOTH: hit = prev_q ^ lvl[i];
                default:   hit = 1'b0;
            endcase
        end

        assign evt[i] = hit;
    end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  bus_req_t                     req,
    input  logic [NUM_LINES-1:0]         evt,
    output logic [NUM_LINES-1:0]         mask_q,
    output logic [NUM_LINES-1:0]         pend_q,
    output logic [NUM_LINES*FIELD_W-1:0] line_codes,
    output logic [REG_W-1:0]             rdata
);
    localparam int CFG_REGS = 2;

    logic [FIELD_W-1:0]        field_q [NUM_PAIRS];
    logic [CFG_REGS*REG_W-1:0] cfg_rd;
    logic [NUM_LINES-1:0]      clr;
    logic                      unused_wbits;

    // Only the low line bits of wdata reach mask and pending.
    assign unused_wbits = ^req.wdata[REG_W-1:NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst)                                 mask_q <= '1;
        else if (req.we && req.addr == ADDR_MASK) mask_q <= req.wdata[NUM_LINES-1:0];
    end

    assign clr = (req.we && req.addr == ADDR_PEND) ? req.wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | evt;
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_field
        localparam int        REG_IDX = k / FIELDS_PER_REG;
        localparam int        LSB     = (k % FIELDS_PER_REG) * NIBBLE_W;
        localparam reg_addr_e MY_ADDR = (REG_IDX == 0) ? ADDR_CFG0 : ADDR_CFG1;

        always_ff @(posedge clk) begin
            if (rst)                               field_q[k] <= '0;
            else if (req.we && req.addr == MY_ADDR) field_q[k] <= req.wdata[LSB +: FIELD_W];
        end
    end

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_code
        assign line_codes[j*FIELD_W +: FIELD_W] = field_q[j/2];
    end

    always_comb begin
        cfg_rd = '0;
        for (int k = 0; k < NUM_PAIRS; k++) begin
            cfg_rd[(k / FIELDS_PER_REG) * REG_W + (k % FIELDS_PER_REG) * NIBBLE_W +: FIELD_W] = field_q[k];
        end
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            ADDR_MASK: rdata[NUM_LINES-1:0] = mask_q;
            ADDR_PEND: rdata[NUM_LINES-1:0] = pend_q;
            ADDR_CFG0: rdata = cfg_rd[0 +: REG_W];
            ADDR_CFG1: rdata = cfg_rd[REG_W +: REG_W];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  ext_pins,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    bus_req_t                     req;
    logic [NUM_LINES-1:0]         pin_sync;
    logic [NUM_LINES-1:0]         line_evt;
    logic [NUM_LINES-1:0]         mask_q;
    logic [NUM_LINES-1:0]         pend_q;
    logic [NUM_LINES-1:0]         live;
    logic [NUM_LINES*FIELD_W-1:0] line_codes;

    assign req.we    = bus_we;
    assign req.addr  = reg_addr_e'(bus_addr);
    assign req.wdata = bus_wdata;

    eirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_pins),
        .q   (pin_sync)
    );

    eirq_detect #(.LINES(NUM_LINES)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .lvl   (pin_sync),
        .codes (line_codes),
        .evt   (line_evt)
    );

    eirq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .evt        (line_evt),
        .mask_q     (mask_q),
        .pend_q     (pend_q),
        .line_codes (line_codes),
        .rdata      (bus_rdata)
    );

    assign live = pend_q & ~mask_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int LO = group_lo(g);
        localparam int HI = group_hi(g);
        assign grp_irq[g] = |live[HI:LO];
    end
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
    import eirq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [REG_W-1:0]      bus_wdata,
    input logic [REG_W-1:0]      bus_rdata,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [NUM_LINES-1:0]  pend_q,
    input logic [NUM_LINES-1:0]  mask_q,
    input logic [NUM_LINES-1:0]  line_evt
);
    logic unused_hi;
    assign unused_hi = ^bus_wdata[REG_W-1:NUM_LINES];

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0 && mask_q == '1 && grp_irq == '0));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_MASK) |=> (mask_q == $past(bus_wdata[NUM_LINES-1:0])));

    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_PEND) |=>
            ((pend_q & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(line_evt)) == '0));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend_q & ~$past(pend_q) & ~$past(line_evt)) == '0));

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (line_evt != '0) |=> ((pend_q & $past(line_evt)) == $past(line_evt)));

    // R8 R9
    group_map_chk: assert property (@(posedge clk) disable iff (rst)
        grp_irq == {|(pend_q[27:20] & ~mask_q[27:20]), |(pend_q[19:12] & ~mask_q[19:12]),
                    |(pend_q[11:4] & ~mask_q[11:4]),   |(pend_q[3:0] & ~mask_q[3:0])});

    // R10
    cfg_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CFG0 || bus_addr == ADDR_CFG1) |-> ((bus_rdata & 32'h8888_8888) == '0));

    // R10
    cfg_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CFG1) |-> (bus_rdata[31:24] == '0));

    // R10
    line_reg_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_MASK || bus_addr == ADDR_PEND) |-> (bus_rdata[31:28] == '0));
endmodule

bind ext_irq_ctrl eirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .line_evt  (line_evt)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] ext_pins = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  grp_irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ext_pins  (ext_pins),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .grp_irq   (grp_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic int grp_of(input int i);
        return (i < 4) ? 0 : (i < 12) ? 1 : (i < 20) ? 2 : 3;
    endfunction

    localparam logic [31:0] BASE0 = 32'h4444_4444;
    localparam logic [31:0] BASE1 = 32'h0044_4444;

    initial begin
        logic [31:0] v;
        logic [2:0]  code;
        logic        idle;
        int          k, nib, g;
        logic [31:0] cfgv;

        // R11: reset state observed while reset is held
        settle(2);
        rd(2'd0, v); chk("R11 mask", v, 32'h0FFF_FFFF);
        rd(2'd1, v); chk("R11 pend", v, 32'h0);
        rd(2'd2, v); chk("R11 cfg0", v, 32'h0);
        rd(2'd3, v); chk("R11 cfg1", v, 32'h0);
        chk("R11 grp", {28'h0, grp_irq}, 32'h0);
        @(negedge clk); rst = 1'b0;

        // R10: padding bits ignore writes
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R10 cfg0 pad", v, 32'h7777_7777);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R10 cfg1 pad", v, 32'h0077_7777);
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R10 mask pad", v, 32'h0FFF_FFFF);
        // R2: mask readback
        wr(2'd0, 32'h0A5A_5A5A); rd(2'd0, v); chk("R2 mask rb", v, 32'h0A5A_5A5A);
        wr(2'd0, 32'hFFFF_FFFF);

        // R3: zero write keeps pending; ones clear (pins steady, rise mode)
        wr(2'd2, BASE0); wr(2'd3, BASE1);
        ext_pins = 28'hFFF_FFFF; settle(4);
        rd(2'd1, v); chk("R3 all rose", v, 32'h0FFF_FFFF);
        wr(2'd1, 32'h0); rd(2'd1, v); chk("R3 zero write", v, 32'h0FFF_FFFF);
        wr(2'd1, 32'h0000_FFFF); rd(2'd1, v); chk("R3 partial clear", v, 32'h0FFF_0000);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R3 full clear", v, 32'h0);

        // Sweep every line through every mode (R1 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 28; i++) begin
            for (int m = 0; m < 5; m++) begin
                case (m)
                    0: begin code = 3'd0;              idle = 1'b1; end
                    1: begin code = 3'd1;              idle = 1'b0; end
                    2: begin code = 3'd2 | 3'(i % 2);  idle = 1'b1; end
                    3: begin code = 3'd4 | 3'(i % 2);  idle = 1'b0; end
                    default: begin code = 3'd6 | 3'(i % 2); idle = 1'b0; end
                endcase
                k = i / 2; nib = k % 8; g = grp_of(i);

                wr(2'd0, 32'hFFFF_FFFF);
                ext_pins = '0;
                wr(2'd2, BASE0); wr(2'd3, BASE1);
                settle(4);
                @(negedge clk);
                ext_pins[i] = idle; ext_pins[i ^ 1] = idle;
                settle(4);
                cfgv = ((k < 8) ? BASE0 : BASE1) & ~(32'hF << (nib * 4));
                cfgv = cfgv | (32'(code) << (nib * 4));
                wr((k < 8) ? 2'd2 : 2'd3, cfgv);
                rd((k < 8) ? 2'd2 : 2'd3, v); chk("R5 field rb", v, cfgv);
                settle(2);
                wr(2'd1, 32'hFFFF_FFFF);
                rd(2'd1, v); chk("R7 idle quiet", v, 32'h0);

                // Active stimulus while masked: latches, no output (R1 R6 R9)
                @(negedge clk);
                ext_pins[i] = ~idle;
                settle(3);
                rd(2'd1, v); chk("R1 R6 latch", v, 32'(1) << i);
                chk("R9 masked quiet", {28'h0, grp_irq}, 32'h0);

                wr(2'd0, ~(32'(1) << i));
                #1 chk("R8 group", {28'h0, grp_irq}, 32'(1) << g);

                if (m < 2) begin
                    // R4: clear during active level is overridden
                    wr(2'd1, 32'(1) << i);
                    rd(2'd1, v); chk("R4 level wins", v, 32'(1) << i);
                    @(negedge clk); ext_pins[i] = idle;
                    settle(3);
                    wr(2'd1, 32'(1) << i);
                    rd(2'd1, v); chk("R4 level gone", v, 32'h0);
                end else begin
                    wr(2'd1, 32'(1) << i);
                    rd(2'd1, v); chk("R7 edge once", v, 32'h0);
                    @(negedge clk); ext_pins[i] = idle;
                    settle(3);
                    rd(2'd1, v);
                    chk("R7 return edge", v, (m == 4) ? (32'(1) << i) : 32'h0);
                    wr(2'd1, 32'hFFFF_FFFF);
                end
                #1 chk("R9 cleared out", {28'h0, grp_irq}, 32'h0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule